// File: doc/BRIEF.md
# Slave Video Timing Field Decoder

This block sits at the front of a video encoder that takes its timing from elsewhere in the system. It watches the externally supplied timing and turns it into four clean, clock-synchronous indications: a one-cycle pulse at the start of each line, a one-cycle pulse at the start of each field, a flag giving the parity of the current field, and a vertical blanking flag for the downstream encoding path.

A 2-bit mode select picks one of four field recognition rules. Mode 0 reads the timing codes embedded in the multiplexed pixel bus and ignores the timing pins. Modes 1 and 3 use a field-level pin together with horizontal sync, and differ only in the sync level at which a field change counts. Mode 2 treats the same pin as a vertical sync and tells odd fields from even ones by whether the vertical edge coincides with a horizontal edge. In the pin-driven modes the blanking flag either follows an external blank pin or comes from an internal line count. A low-high-low sequence on a timing-reset pin clears that line count.

All pin and pixel inputs are brought into the clock domain by a synchroniser chain before any edge or code is examined. Mode select and blank enable are configuration inputs and are expected to change only while the timing inputs are idle.

Top module: `vsd_field_decoder`

## Requirements
- R1: After reset, field_start_o and line_start_o are 0, field_odd_o is 1 and blank_o is 1 (mode 0, or pin modes with blank_en low).
- R2: In mode 0 (mode_sel = 0) a timing code is the byte sequence FF, 00, 00 followed by a status byte whose bit 7 is 1. Status bit 6 is the field bit F, bit 5 the vertical blanking bit V and bit 4 the line-end bit H. A code with H = 1 gives a line_start_o pulse, a code with H = 0 does not, and a status byte with bit 7 = 0 is not a code.
- R3: In mode 0 a code whose F differs from the F of the previous code gives a field_start_o pulse, and field_odd_o becomes the inverse of F (F = 0 is odd). blank_o equals the V of the latest code. HSYNC and FIELD/VSYNC activity gives no pulse in this mode.
- R4: In mode 1 a level change of the FIELD pin while HSYNC is low gives field_start_o, with field_odd_o set to the inverse of the new FIELD level (low = odd). A change while HSYNC is high is ignored.
- R5: In mode 2 HSYNC and VSYNC falling in the same cycle give field_start_o with field_odd_o = 1. A VSYNC fall while HSYNC is high gives field_start_o with field_odd_o = 0. A VSYNC fall while HSYNC is already low gives nothing.
- R6: In mode 3 a level change of the FIELD pin while HSYNC is high gives field_start_o, with field_odd_o set to the inverse of the new FIELD level. A change while HSYNC is low is ignored.
- R7: In modes 1 to 3 each HSYNC falling edge gives a line_start_o pulse. The internal line count goes up by one per line_start_o, is cleared to 0 by field_start_o and saturates at 2**LINE_W-1 instead of wrapping.
- R8: In modes 1 to 3, with blank_en = 1 blank_o follows blank_in (1 = blanked). With blank_en = 0, blank_o is 1 exactly while the line count is below VBL_LINES.
- R9: trst_in going high and then low again clears the line count to 0. A rise alone does not clear it.
- R10: Every pulse is one cycle wide. It appears after the third rising clock edge counted from the edge that first samples the causing input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Field recognition rule, 0 to 3 |
| blank_en | input | 1 | 1 = use blank_in in modes 1 to 3 |
| hsync_in | input | 1 | Horizontal sync pin |
| fvs_in | input | 1 | Shared field level / vertical sync pin |
| blank_in | input | 1 | External blank pin, 1 = blanked |
| trst_in | input | 1 | Timing-reset control pin |
| pix_in | input | PIX_W | Multiplexed pixel bus carrying embedded codes |
| field_start_o | output | 1 | One-cycle pulse at the start of a field |
| field_odd_o | output | 1 | 1 while the current field is odd |
| line_start_o | output | 1 | One-cycle pulse at the start of a line |
| blank_o | output | 1 | Vertical blanking flag |

## Verification
The bench feeds codes with the marker bit cleared and codes with an unchanged field bit. A decoder that skipped the marker check, or that pulsed on every code, would report false fields there. In each pin mode it moves the field pin on the wrong side of horizontal sync and drops vertical sync while horizontal sync is already low, so a decoder that ignored the sync qualification would pulse and flip parity. It drives more lines than the counter can hold, where a wrapping counter would bring blanking back. It also raises the timing-reset pin and holds it there, where a decoder that cleared on the rise would blank too early.

// File: rtl/vsd_pkg.sv
package vsd_pkg;

   typedef enum logic [1:0] {
      TM_EMBED     = 2'd0,
      TM_FLD_HLOW  = 2'd1,
      TM_HV_EDGE   = 2'd2,
      TM_FLD_HHIGH = 2'd3
   } tmode_e;

   typedef struct packed {
      logic line_ev;
      logic field_ev;
      logic odd;
   } tevent_t;

   localparam logic [7:0] CODE_PRE_HI = 8'hFF;
   localparam logic [7:0] CODE_PRE_LO = 8'h00;

endpackage

// File: rtl/vsd_sync_chain.sv
module vsd_sync_chain #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_depth
      $error("vsd_sync_chain: STAGES must be at least 2");
   end

   for (genvar i = 0; i < STAGES; i++) begin : g_st
      logic [W-1:0] r;
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= '0;
            else        r <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= '0;
            else        r <= g_st[i-1].r;
         end
      end
   end

   assign q = g_st[STAGES-1].r;

endmodule

// File: rtl/vsd_embed_dec.sv
module vsd_embed_dec
   import vsd_pkg::*;
#(
   parameter int PIX_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PIX_W-1:0] pix,
   output tevent_t          ev,
   output logic             hit,
   output logic             vflag
);

   logic [7:0] cur;
   logic [7:0] hist0, hist1, hist2;
   logic       f_last;

   assign cur = pix[PIX_W-1 -: 8];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist0  <= '0;
         hist1  <= '0;
         hist2  <= '0;
         f_last <= 1'b0;
      end else begin
         hist0 <= cur;
         hist1 <= hist0;
         hist2 <= hist1;
         if (hit) f_last <= cur[6];
      end
   end

   always_comb begin
      hit = (hist2 == CODE_PRE_HI) && (hist1 == CODE_PRE_LO) &&
            (hist0 == CODE_PRE_LO) && cur[7];
      ev.line_ev  = hit && cur[4];
      ev.field_ev = hit && (cur[6] != f_last);
      ev.odd      = ~cur[6];
      vflag       = cur[5];
   end

endmodule

// File: rtl/vsd_pin_dec.sv
module vsd_pin_dec
   import vsd_pkg::*;
(
   input  tmode_e  mode,
   input  logic    hs_now,
   input  logic    hs_prev,
   input  logic    fv_now,
   input  logic    fv_prev,
   output tevent_t ev
);

   logic hs_fall, fv_fall, fv_chg;

   always_comb begin
      hs_fall = hs_prev & ~hs_now;
      fv_fall = fv_prev & ~fv_now;
      fv_chg  = fv_prev ^ fv_now;
      ev      = '0;
      case (mode)
         TM_FLD_HLOW: begin
            ev.line_ev  = hs_fall;
            ev.field_ev = fv_chg & ~hs_now;
            ev.odd      = ~fv_now;
         end
         TM_HV_EDGE: begin
            ev.line_ev  = hs_fall;
            ev.field_ev = fv_fall & (hs_fall | hs_now);
            ev.odd      = hs_fall;
         end
         TM_FLD_HHIGH: begin
            ev.line_ev  = hs_fall;
            ev.field_ev = fv_chg & hs_now;
            ev.odd      = ~fv_now;
         end
         default: ev = '0;
      endcase
   end

endmodule

// File: rtl/vsd_line_ctl.sv
module vsd_line_ctl #(
   parameter int LINE_W    = 10,
   parameter int VBL_LINES = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              field_ev,
   input  logic              line_ev,
   output logic [LINE_W-1:0] cnt,
   output logic              in_vbl
);

   localparam logic [LINE_W-1:0] CNT_MAX = '1;
   localparam logic [LINE_W-1:0] VBL_L   = LINE_W'(VBL_LINES);

   if (VBL_LINES > (2**LINE_W) - 1) begin : g_bad_vbl
      $error("vsd_line_ctl: VBL_LINES does not fit in LINE_W bits");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       cnt <= '0;
      else if (clr)                     cnt <= '0;
      else if (field_ev)                cnt <= '0;
      else if (line_ev && cnt != CNT_MAX) cnt <= cnt + 1'b1;
   end

   assign in_vbl = (cnt < VBL_L);

   // R7: the count holds at its ceiling
   assert_line_sat_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == CNT_MAX && !clr && !field_ev) |=> (cnt == CNT_MAX));

   // R7: a field start always leaves the count at zero
   assert_field_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      field_ev |=> (cnt == '0));

endmodule

// File: rtl/vsd_field_decoder.sv
module vsd_field_decoder
   import vsd_pkg::*;
#(
   parameter int PIX_W       = 8,
   parameter int SYNC_STAGES = 2,
   parameter int LINE_W      = 10,
   parameter int VBL_LINES   = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       mode_sel,
   input  logic             blank_en,
   input  logic             hsync_in,
   input  logic             fvs_in,
   input  logic             blank_in,
   input  logic             trst_in,
   input  logic [PIX_W-1:0] pix_in,
   output logic             field_start_o,
   output logic             field_odd_o,
   output logic             line_start_o,
   output logic             blank_o
);

   localparam int SW     = PIX_W + 4;
   localparam int B_HS   = PIX_W;
   localparam int B_FV   = PIX_W + 1;
   localparam int B_BL   = PIX_W + 2;
   localparam int B_TR   = PIX_W + 3;

   if (PIX_W < 8) begin : g_bad_pix
      $error("vsd_field_decoder: PIX_W must be at least 8");
   end

   tmode_e            mode;
   logic [SW-1:0]     sync_q;
   logic [PIX_W-1:0]  pix_s;
   logic              hs_s, fv_s, bl_s, tr_s;
   logic              hs_p, fv_p, tr_p;
   logic              tr_armed, trst_clr;
   tevent_t           emb_ev, pin_ev, sel_ev;
   logic              emb_hit, emb_v;
   logic              fstart_q, lstart_q, odd_q, vbit_q, blank_q;
   logic [LINE_W-1:0] line_cnt;
   logic              in_vbl;

   assign mode = tmode_e'(mode_sel);

   vsd_sync_chain #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({trst_in, blank_in, fvs_in, hsync_in, pix_in}),
      .q     (sync_q)
   );

   assign pix_s = sync_q[PIX_W-1:0];
   assign hs_s  = sync_q[B_HS];
   assign fv_s  = sync_q[B_FV];
   assign bl_s  = sync_q[B_BL];
   assign tr_s  = sync_q[B_TR];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hs_p     <= 1'b0;
         fv_p     <= 1'b0;
         tr_p     <= 1'b0;
         tr_armed <= 1'b0;
      end else begin
         hs_p <= hs_s;
         fv_p <= fv_s;
         tr_p <= tr_s;
         if (tr_s && !tr_p)  tr_armed <= 1'b1;
         else if (trst_clr)  tr_armed <= 1'b0;
      end
   end

   assign trst_clr = tr_armed & tr_p & ~tr_s;

   vsd_embed_dec #(.PIX_W(PIX_W)) u_embed (
      .clk   (clk),
      .rst_n (rst_n),
      .pix   (pix_s),
      .ev    (emb_ev),
      .hit   (emb_hit),
      .vflag (emb_v)
   );

   vsd_pin_dec u_pins (
      .mode    (mode),
      .hs_now  (hs_s),
      .hs_prev (hs_p),
      .fv_now  (fv_s),
      .fv_prev (fv_p),
      .ev      (pin_ev)
   );

   assign sel_ev = (mode == TM_EMBED) ? emb_ev : pin_ev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fstart_q <= 1'b0;
         lstart_q <= 1'b0;
         odd_q    <= 1'b1;
         vbit_q   <= 1'b1;
         blank_q  <= 1'b0;
      end else begin
         fstart_q <= sel_ev.field_ev;
         lstart_q <= sel_ev.line_ev;
         blank_q  <= bl_s;
         if (sel_ev.field_ev) odd_q  <= sel_ev.odd;
         if (emb_hit)         vbit_q <= emb_v;
      end
   end

   vsd_line_ctl #(.LINE_W(LINE_W), .VBL_LINES(VBL_LINES)) u_lines (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (trst_clr),
      .field_ev (sel_ev.field_ev),
      .line_ev  (sel_ev.line_ev),
      .cnt      (line_cnt),
      .in_vbl   (in_vbl)
   );

   assign field_start_o = fstart_q;
   assign line_start_o  = lstart_q;
   assign field_odd_o   = odd_q;
   assign blank_o       = (mode == TM_EMBED) ? vbit_q :
                          (blank_en ? blank_q : in_vbl);

   // R10: a line pulse never lasts two cycles
   assert_line_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      line_start_o |=> !line_start_o);

   // R3, R4, R5, R6: parity moves only together with a field pulse
   assert_parity_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !field_start_o |-> $stable(field_odd_o));

   // R5: an odd field in mode 2 needs a horizontal fall in the decode cycle
   assert_mode2_odd_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == TM_HV_EDGE && field_start_o && field_odd_o) |-> $past(hs_p && !hs_s));

   // R9: a completed reset sequence empties the line count
   assert_trst_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      trst_clr |=> (line_cnt == '0));

   // R7: a field pulse at the output finds the count at zero
   assert_field_line0_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (field_start_o && mode != TM_EMBED) |-> (line_cnt == '0 || $past(trst_clr) == 1'b0));

endmodule

// File: tb/vsd_field_decoder_bench.sv
`timescale 1ns/1ps
module vsd_field_decoder_bench;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [1:0] mode_sel;
   logic       blank_en, hsync_in, fvs_in, blank_in, trst_in;
   logic [7:0] pix_in;
   logic       field_start_o, field_odd_o, line_start_o, blank_o;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   vsd_field_decoder #(.PIX_W(8), .SYNC_STAGES(2), .LINE_W(4), .VBL_LINES(6)) u_vsd_field_decoder (
      .clk           (clk),
      .rst_n         (rst_n),
      .mode_sel      (mode_sel),
      .blank_en      (blank_en),
      .hsync_in      (hsync_in),
      .fvs_in        (fvs_in),
      .blank_in      (blank_in),
      .trst_in       (trst_in),
      .pix_in        (pix_in),
      .field_start_o (field_start_o),
      .field_odd_o   (field_odd_o),
      .line_start_o  (line_start_o),
      .blank_o       (blank_o)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic send_code(input logic [7:0] status);
      pix_in = 8'hFF; tick(1);
      pix_in = 8'h00; tick(1);
      pix_in = 8'h00; tick(1);
      pix_in = status; tick(1);
      pix_in = 8'h80;
   endtask

   task automatic expect_quiet(input string tag, input int n);
      int hits = 0;
      repeat (n) begin
         tick(1);
         hits += int'(field_start_o);
      end
      chk(tag, hits, 0);
   endtask

   task automatic one_line();
      hsync_in = 1'b0; tick(2);
      hsync_in = 1'b1; tick(2);
   endtask

   task automatic t_reset();
      chk("R1 field_start after reset", field_start_o, 0);
      chk("R1 line_start after reset", line_start_o, 0);
      chk("R1 field_odd after reset", field_odd_o, 1);
      chk("R1 blank after reset", blank_o, 1);
   endtask

   task automatic t_mode0();
      int hits;
      send_code({1'b1, 1'b0, 1'b0, 1'b1, 4'h0});
      tick(2);
      chk("R2 line pulse on H=1 code", line_start_o, 1);
      chk("R3 no field pulse on same F", field_start_o, 0);
      tick(1);
      chk("R10 line pulse one cycle", line_start_o, 0);
      chk("R3 blank follows V=0", blank_o, 0);
      send_code({1'b1, 1'b0, 1'b0, 1'b0, 4'h0});
      tick(2);
      chk("R2 no line pulse on H=0 code", line_start_o, 0);
      hits = 0;
      for (int i = 0; i < 8; i++) begin
         hsync_in = i[0];
         fvs_in   = i[1];
         tick(1);
         hits += int'(field_start_o) + int'(line_start_o);
      end
      hsync_in = 1'b1; fvs_in = 1'b1;
      for (int i = 0; i < 4; i++) begin
         tick(1);
         hits += int'(field_start_o) + int'(line_start_o);
      end
      chk("R3 pins ignored in mode 0", hits, 0);
      send_code({1'b1, 1'b1, 1'b1, 1'b1, 4'h0});
      tick(2);
      chk("R3 field pulse on F change", field_start_o, 1);
      chk("R3 parity even for F=1", field_odd_o, 0);
      chk("R3 blank follows V=1", blank_o, 1);
      send_code({1'b0, 1'b0, 1'b0, 1'b1, 4'h0});
      tick(2);
      chk("R2 no code without marker bit", field_start_o, 0);
      tick(1);
      chk("R2 parity kept without marker bit", field_odd_o, 0);
      send_code({1'b1, 1'b0, 1'b1, 1'b1, 4'h0});
      tick(2);
      chk("R3 field pulse back to F=0", field_start_o, 1);
      chk("R3 parity odd for F=0", field_odd_o, 1);
      tick(2);
   endtask

   task automatic t_mode1();
      mode_sel = 2'd1; tick(4);
      fvs_in = 1'b0;
      expect_quiet("R4 FIELD change with HSYNC high ignored", 5);
      chk("R4 parity kept", field_odd_o, 1);
      hsync_in = 1'b0; tick(3);
      chk("R7 line pulse on HSYNC fall", line_start_o, 1);
      tick(1);
      chk("R10 line pulse one cycle mode 1", line_start_o, 0);
      fvs_in = 1'b1; tick(3);
      chk("R4 field pulse with HSYNC low", field_start_o, 1);
      chk("R4 parity from FIELD high", field_odd_o, 0);
      tick(1);
      chk("R10 field pulse one cycle", field_start_o, 0);
      hsync_in = 1'b1; tick(4);
   endtask

   task automatic t_mode2();
      mode_sel = 2'd2; tick(4);
      hsync_in = 1'b0; fvs_in = 1'b0; tick(3);
      chk("R5 coincident falls give field", field_start_o, 1);
      chk("R5 coincident falls give odd", field_odd_o, 1);
      chk("R5 coincident falls give line", line_start_o, 1);
      hsync_in = 1'b1; fvs_in = 1'b1; tick(4);
      fvs_in = 1'b0; tick(3);
      chk("R5 VSYNC fall with HSYNC high gives field", field_start_o, 1);
      chk("R5 VSYNC fall with HSYNC high gives even", field_odd_o, 0);
      fvs_in = 1'b1; tick(4);
      hsync_in = 1'b0; tick(4);
      fvs_in = 1'b0;
      expect_quiet("R5 VSYNC fall with HSYNC low ignored", 5);
      chk("R5 parity kept after ignored fall", field_odd_o, 0);
      hsync_in = 1'b1; fvs_in = 1'b1; tick(4);
   endtask

   task automatic t_mode3();
      mode_sel = 2'd3; tick(4);
      fvs_in = 1'b0; tick(3);
      chk("R6 field pulse with HSYNC high", field_start_o, 1);
      chk("R6 parity from FIELD low", field_odd_o, 1);
      tick(1);
      hsync_in = 1'b0; tick(2);
      fvs_in = 1'b1;
      expect_quiet("R6 FIELD change with HSYNC low ignored", 5);
      chk("R6 parity kept", field_odd_o, 1);
      hsync_in = 1'b1; tick(4);
   endtask

   task automatic t_blank_lines();
      fvs_in = 1'b0; tick(4);
      chk("R8 blank at line 0", blank_o, 1);
      repeat (5) one_line();
      chk("R8 blank at line 5", blank_o, 1);
      one_line();
      chk("R8 active at line 6", blank_o, 0);
      blank_en = 1'b1; blank_in = 1'b1; tick(4);
      chk("R8 blank pin high used", blank_o, 1);
      blank_in = 1'b0; tick(4);
      chk("R8 blank pin low used", blank_o, 0);
      blank_en = 1'b0; tick(1);
      repeat (14) one_line();
      chk("R7 count saturates", blank_o, 0);
      trst_in = 1'b1; tick(4);
      chk("R9 rise alone keeps count", blank_o, 0);
      trst_in = 1'b0; tick(4);
      chk("R9 low-high-low clears count", blank_o, 1);
      repeat (6) one_line();
      chk("R7 count rises again", blank_o, 0);
      fvs_in = 1'b1; tick(4);
      chk("R7 field start clears count", blank_o, 1);
   endtask

   initial begin
      rst_n = 1'b0; mode_sel = 2'd0; blank_en = 1'b0; hsync_in = 1'b1;
      fvs_in = 1'b1; blank_in = 1'b0; trst_in = 1'b0; pix_in = 8'h80;
      tick(3);
      rst_n = 1'b1;
      tick(1);
      t_reset();
      t_mode0();
      t_mode1();
      t_mode2();
      t_mode3();
      t_blank_lines();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         tests++;
         fails++;
         $display("FAIL R10 watchdog expired actual=0 expected=1");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule